// File: doc/BRIEF.md
# Size-Changing Vector Load/Store Unit

The unit moves one 128-bit vector between a byte-addressed memory port and an internal vector register. It works in four beats, each covering one 32-bit quarter of the vector, and issues exactly one memory access per beat. The width conversion happens inside that access. On a load, memory elements of 8, 16 or 32 bits are zero- or sign-extended to the lane width. On a store, each lane is cut down to the memory element width. The memory access in each beat is sized to hold every element of that beat, so no separate widening pass is ever needed.

A request gives two size codes (0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = reserved): the memory element size and the lane size. It also gives a sign-extend flag, pre- or post-increment addressing, a writeback enable, a base address and a signed immediate. Data is little-endian, and lane 0 sits at the lowest address.

The controller has five states. IDLE accepts a request and moves to ISSUE if the size pair is legal, or to REJECT if it is not. ISSUE drives one memory access. A store moves from ISSUE to the next ISSUE, or to FINISH after beat 3. A load moves from ISSUE to WAIT. WAIT captures and extends the read data, then moves to ISSUE for the next beat, or to FINISH after beat 3. FINISH and REJECT both pulse done and return to IDLE.

Top module: `vldst_unit`

## Requirements
- R1: A legal request accepted in IDLE makes exactly four memory accesses. busy is high from the cycle after acceptance until the last beat completes, and mem_req is never high while busy is low.
- R2: Every beat access has size code 2 - (lane code - memory code), which is 4·mbytes/lbytes bytes. Beat k accesses start + k·(that byte count). A store's beat accesses come on back-to-back cycles.
- R3: A widening load with the sign-extend flag low fills the upper bits of each lane with zeros.
- R4: A widening load with the sign-extend flag high fills the upper bits of each lane with copies of the element's top bit.
- R5: A load with equal sizes (8→8, 16→16, 32→32) returns the 16 memory bytes unchanged. Byte i of memory lands in vector bits 8i+7..8i.
- R6: A narrowing store writes the low mbytes of each lane, with lane k at start + k·mbytes. It leaves the byte after the last element unchanged.
- R7: In pre-increment mode the access starts at base + imm, and the writeback address is base + imm.
- R8: In post-increment mode the access starts at base, and the writeback address is base + (16/lbytes)·mbytes.
- R9: A request whose memory size is larger than its lane size, or that uses code 3, is rejected. In the next cycle done and illegal are high, busy stays low, and no memory access occurs.
- R10: done is high for exactly one cycle and never together with busy. A request presented while busy or done is ignored.
- R11: wb_valid is high only in the done cycle of a legal request whose writeback enable was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken only in IDLE) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_msz | input | 2 | Memory element size code |
| req_lsz | input | 2 | Lane size code |
| req_sext | input | 1 | Sign-extend on widening load |
| req_pre | input | 1 | 1 = pre-increment, 0 = post-increment |
| req_wb | input | 1 | Writeback address requested |
| req_base | input | ADDR_W | Base address |
| req_imm | input | ADDR_W | Signed pre-increment offset |
| req_vec | input | 128 | Store source vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Request rejected (with done) |
| ld_vec | output | 128 | Loaded vector, valid with done |
| wb_valid | output | 1 | Writeback address valid |
| wb_addr | output | ADDR_W | Updated base address |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of access |
| mem_size | output | 2 | Access size code (0=1, 1=2, 2=4 bytes) |
| mem_wdata | output | 32 | Write data, low bytes first |
| mem_rdata | input | 32 | Read data, one cycle after the request |

## Verification
A beat counter that is off by one shows up as a fifth or a missing access, or as a vector quarter that is shifted or stale, as soon as the done pulse arrives. A wrong size code in the captured request shows up on the first beat as a wrong mem_size and as lane data extended from the wrong bytes. A controller stuck in the wrong state shows up within a cycle: busy and done overlap, done is held high, a rejected pair reaches the memory port, or a request arriving mid-operation is taken and changes the result or the writeback address. Memory bytes just past a narrowing store expose any overwrite beyond the last element.

// File: rtl/vls_pkg.sv
package vls_pkg;
    localparam int BEATS  = 4;
    localparam int BEAT_W = 32;
    localparam int VEC_W  = BEATS * BEAT_W;

    typedef logic [1:0] esize_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH,
        ST_REJECT
    } vls_state_e;

    // legal: memory element no wider than lane, no reserved code
    function automatic logic pair_ok(esize_t m, esize_t l);
        return (m != 2'd3) && (l != 2'd3) && (m <= l);
    endfunction
endpackage

// File: rtl/vls_agen.sv
module vls_agen
    import vls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] imm,
    input  logic              pre,
    input  esize_t            msz,
    input  esize_t            lsz,
    input  logic [1:0]        beat,
    output logic [ADDR_W-1:0] beat_addr,
    output esize_t            beat_sz,
    output logic [ADDR_W-1:0] next_base
);
    logic [1:0]        ratio;
    logic [ADDR_W-1:0] start;

    always_comb begin
        ratio     = lsz - msz;
        beat_sz   = 2'd2 - ratio;
        start     = pre ? (base + imm) : base;
        beat_addr = start + (ADDR_W'(beat) << beat_sz);
        next_base = pre ? start : (base + (ADDR_W'(4) << beat_sz));
    end
endmodule

// File: rtl/vls_widen.sv
module vls_widen
    import vls_pkg::*;
(
    input  logic [BEAT_W-1:0] raw,
    input  esize_t            msz,
    input  esize_t            lsz,
    input  logic              sext,
    output logic [BEAT_W-1:0] lanes
);
    logic hi0, hi1, hi16;

    always_comb begin
        hi0   = sext & raw[7];
        hi1   = sext & raw[15];
        hi16  = sext & raw[15];
        lanes = raw;
        case ({msz, lsz})
            4'b0001: lanes = {{8{hi1}}, raw[15:8], {8{hi0}}, raw[7:0]};
            4'b0010: lanes = {{24{hi0}}, raw[7:0]};
            4'b0110: lanes = {{16{hi16}}, raw[15:0]};
            default: lanes = raw;
        endcase
    end
endmodule

// File: rtl/vls_narrow.sv
module vls_narrow
    import vls_pkg::*;
(
    input  logic [BEAT_W-1:0] lanes,
    input  esize_t            msz,
    input  esize_t            lsz,
    output logic [BEAT_W-1:0] packed_out
);
    always_comb begin
        case ({msz, lsz})
            4'b0001: packed_out = {16'h0, lanes[23:16], lanes[7:0]};
            4'b0010: packed_out = {24'h0, lanes[7:0]};
            4'b0110: packed_out = {16'h0, lanes[15:0]};
            default: packed_out = lanes;
        endcase
    end
endmodule

// File: rtl/vldst_unit.sv
module vldst_unit
    import vls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_msz,
    input  logic [1:0]        req_lsz,
    input  logic              req_sext,
    input  logic              req_pre,
    input  logic              req_wb,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_imm,
    input  logic [127:0]      req_vec,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [127:0]      ld_vec,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    localparam int BEAT_IDX_W = $clog2(BEATS);
    localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(BEATS - 1);

    vls_state_e            state_q, state_d;
    logic [BEAT_IDX_W-1:0] beat_q;
    logic                  store_q, sext_q, pre_q, wb_q;
    esize_t                msz_q, lsz_q;
    logic [ADDR_W-1:0]     base_q, imm_q;

    logic                  accept, last_beat, beat_adv;
    logic [BEAT_W-1:0]     beat_words [BEATS];
    logic [BEAT_W-1:0]     widened, narrowed;
    esize_t                beat_sz;
    logic [ADDR_W-1:0]     next_base;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign last_beat = (beat_q == LAST_BEAT);
    assign beat_adv  = (state_q == ST_WAIT) || ((state_q == ST_ISSUE) && store_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = pair_ok(req_msz, req_lsz) ? ST_ISSUE : ST_REJECT;
            ST_ISSUE:  if (!store_q)       state_d = ST_WAIT;
                       else if (last_beat) state_d = ST_FINISH;
            ST_WAIT:   state_d = last_beat ? ST_FINISH : ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept)        beat_q <= '0;
            else if (beat_adv) beat_q <= beat_q + 1'b1;
        end
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            sext_q  <= 1'b0;
            pre_q   <= 1'b0;
            wb_q    <= 1'b0;
            msz_q   <= '0;
            lsz_q   <= '0;
            base_q  <= '0;
            imm_q   <= '0;
        end else if (accept) begin
            store_q <= req_store;
            sext_q  <= req_sext;
            pre_q   <= req_pre;
            wb_q    <= req_wb;
            msz_q   <= req_msz;
            lsz_q   <= req_lsz;
            base_q  <= req_base;
            imm_q   <= req_imm;
        end
    end

    // one quarter register per beat: loaded from the store source, refilled by loads
    for (genvar g = 0; g < BEATS; g++) begin : g_quarter
        logic [BEAT_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (accept)
                word_q <= req_vec[g*BEAT_W +: BEAT_W];
            else if ((state_q == ST_WAIT) && (beat_q == BEAT_IDX_W'(g)))
                word_q <= widened;
        end
        assign beat_words[g]                = word_q;
        assign ld_vec[g*BEAT_W +: BEAT_W]   = word_q;
    end

    vls_agen #(.ADDR_W(ADDR_W)) u_agen (
        .base      (base_q),
        .imm       (imm_q),
        .pre       (pre_q),
        .msz       (msz_q),
        .lsz       (lsz_q),
        .beat      (beat_q),
        .beat_addr (mem_addr),
        .beat_sz   (beat_sz),
        .next_base (next_base)
    );

    vls_widen u_widen (
        .raw   (mem_rdata),
        .msz   (msz_q),
        .lsz   (lsz_q),
        .sext  (sext_q),
        .lanes (widened)
    );

    vls_narrow u_narrow (
        .lanes      (beat_words[beat_q]),
        .msz        (msz_q),
        .lsz        (lsz_q),
        .packed_out (narrowed)
    );

    assign mem_size  = beat_sz;
    assign mem_wdata = narrowed;
    assign wb_addr   = next_base;

    // outputs
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        illegal  = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        wb_valid = 1'b0;
        unique case (state_q)
            ST_ISSUE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = store_q;
            end
            ST_WAIT:   busy = 1'b1;
            ST_FINISH: begin
                done     = 1'b1;
                wb_valid = wb_q;
            end
            ST_REJECT: begin
                done    = 1'b1;
                illegal = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vls_chk.sv
module vls_chk
    import vls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_msz,
    input logic [1:0]        req_lsz,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              wb_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size
);
    logic take;
    assign take = req_valid && !busy && !done;

    AST_QUIET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);  // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pair_ok(req_msz, req_lsz)) |=> busy);  // R1

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |->
        ($stable(mem_size) && (mem_addr == $past(mem_addr) + (ADDR_W'(1) << $past(mem_size)))));  // R2

    AST_BAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !pair_ok(req_msz, req_lsz)) |=> (done && illegal && !busy && !mem_req));  // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));  // R10

    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (done && !illegal));  // R11
endmodule

bind vldst_unit vls_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_msz   (req_msz),
    .req_lsz   (req_lsz),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .wb_valid  (wb_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size)
);

// File: tb/vldst_unit_tb.sv
module vldst_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_store = 1'b0, req_sext = 1'b0, req_pre = 1'b0, req_wb = 1'b0;
    logic [1:0]   req_msz = '0, req_lsz = '0;
    logic [31:0]  req_base = '0, req_imm = '0;
    logic [127:0] req_vec = '0;
    logic         busy, done, illegal, wb_valid, mem_req, mem_we;
    logic [127:0] ld_vec;
    logic [31:0]  wb_addr, mem_addr, mem_wdata;
    logic [31:0]  mem_rdata = '0;
    logic [1:0]   mem_size;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vldst_unit #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_msz(req_msz), .req_lsz(req_lsz), .req_sext(req_sext), .req_pre(req_pre),
        .req_wb(req_wb), .req_base(req_base), .req_imm(req_imm), .req_vec(req_vec),
        .busy(busy), .done(done), .illegal(illegal), .ld_vec(ld_vec),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model and a shadow copy kept by the driver
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < (1 << mem_size); b++)
                    mem[8'(mem_addr + 32'(b))] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                              mem[8'(mem_addr + 1)], mem[8'(mem_addr)]};
            end
        end
    end

    // access tracking: reset on an accepted request
    int         acc_cnt = 0;
    logic [31:0] first_a = '0;
    logic [1:0]  first_sz = '0;
    always @(posedge clk) begin
        if (req_valid && !busy && !done) acc_cnt <= 0;
        else if (mem_req) begin
            if (acc_cnt == 0) begin
                first_a  <= mem_addr;
                first_sz <= mem_size;
            end
            acc_cnt <= acc_cnt + 1;
        end
    end

    typedef struct {
        logic         is_st;
        logic         ill;
        logic [127:0] vec;
        logic         wbv;
        logic [31:0]  wba;
        logic [31:0]  a0;
        logic [1:0]   sz;
        int           n_acc;
        int           st_len;
    } exp_t;

    exp_t  sb[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 128'(done), 128'(0));
            end else begin
                exp_t  e;
                string t;
                e = sb.pop_front();
                t = tag_q.pop_front();
                chk(illegal == e.ill, {t, " illegal flag"}, 128'(illegal), 128'(e.ill));
                chk(acc_cnt == e.n_acc, {t, " access count"}, 128'(acc_cnt), 128'(e.n_acc));
                chk(wb_valid == e.wbv, {"R11 ", t, " wb_valid"}, 128'(wb_valid), 128'(e.wbv));
                if (e.wbv)
                    chk(wb_addr == e.wba, {t, " writeback address"}, 128'(wb_addr), 128'(e.wba));
                if (!e.ill) begin
                    chk(first_a == e.a0 && first_sz == e.sz, {"R2 ", t, " first access addr/size"},
                        {first_sz, first_a}, {e.sz, e.a0});
                    if (!e.is_st)
                        chk(ld_vec == e.vec, {t, " load vector"}, ld_vec, e.vec);
                    else begin
                        logic ok;
                        ok = 1'b1;
                        for (int i = 0; i <= e.st_len; i++)
                            if (mem[8'(e.a0 + 32'(i))] !== ref_mem[8'(e.a0 + 32'(i))]) ok = 1'b0;
                        chk(ok, {"R6 ", t, " stored bytes and next byte"}, 128'(e.st_len), 128'(e.st_len));
                    end
                end
            end
        end
    end

    function automatic logic [127:0] ref_load(logic [31:0] a, int msz, int lsz, logic sx);
        logic [127:0] v;
        int nl, mb, lb;
        v  = '0;
        mb = 1 << msz;
        lb = 1 << lsz;
        nl = 16 / lb;
        for (int k = 0; k < nl; k++) begin
            logic [31:0] el;
            el = '0;
            for (int b = 0; b < mb; b++)
                el[8*b +: 8] = ref_mem[8'(a + 32'(k*mb + b))];
            if (sx && el[8*mb-1])
                for (int b = mb; b < 4; b++) el[8*b +: 8] = 8'hFF;
            for (int b = 0; b < lb; b++)
                v[8*(k*lb + b) +: 8] = el[8*b +: 8];
        end
        return v;
    endfunction

    task automatic ref_store(logic [31:0] a, int msz, int lsz, logic [127:0] v);
        int mb, lb;
        mb = 1 << msz;
        lb = 1 << lsz;
        for (int k = 0; k < 16 / lb; k++)
            for (int b = 0; b < mb; b++)
                ref_mem[8'(a + 32'(k*mb + b))] = v[8*(k*lb + b) +: 8];
    endtask

    // driver: computes the expectation, pushes it, runs the request
    task automatic do_op(input string tag, input logic st, input int msz, input int lsz,
                         input logic sx, input logic pre, input logic wb,
                         input logic [31:0] base, input logic [31:0] imm,
                         input logic [127:0] v, input bit poke);
        exp_t e;
        logic [31:0] start;
        bit legal, busy_ok;
        int tot;
        legal   = (msz < 3) && (lsz < 3) && (msz <= lsz);
        start   = pre ? base + imm : base;
        tot     = legal ? (16 >> lsz) * (1 << msz) : 0;
        e.is_st = st;
        e.ill   = !legal;
        e.vec   = '0;
        e.wbv   = legal && wb;
        e.wba   = pre ? start : base + 32'(tot);
        e.a0    = start;
        e.sz    = legal ? 2'(2 - (lsz - msz)) : 2'd0;
        e.n_acc = legal ? 4 : 0;
        e.st_len = tot;
        if (legal && !st) e.vec = ref_load(start, msz, lsz, sx);
        if (legal && st)  ref_store(start, msz, lsz, v);
        sb.push_back(e);
        tag_q.push_back(tag);

        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_msz = 2'(msz); req_lsz = 2'(lsz);
        req_sext = sx; req_pre = pre; req_wb = wb; req_base = base; req_imm = imm; req_vec = v;
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal) begin
            chk(done && illegal && !busy, "R9 rejected in next cycle", {busy, done, illegal}, 3'b011);
        end else begin
            chk(busy && !done, "R1 busy after accept", {busy, done}, 2'b10);
            busy_ok = 1'b1;
            if (poke) begin
                @(negedge clk);
                if (!busy) busy_ok = 1'b0;
                req_valid = 1'b1; req_base = 32'h55; req_msz = 2'd3; req_store = ~st;
                @(negedge clk);
                req_valid = 1'b0;
            end
            while (!done) begin
                if (!busy) busy_ok = 1'b0;
                @(negedge clk);
            end
            chk(busy_ok, "R1 busy held until last beat", 128'(busy_ok), 128'(1));
        end
        if (poke) begin
            req_valid = 1'b1; req_msz = 2'd0; req_lsz = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
            chk(!busy && !done, "R10 request during done ignored", {busy, done}, 2'b00);
        end else begin
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'((i * 73 + 29) ^ (i << 3));
            ref_mem[i] = 8'((i * 73 + 29) ^ (i << 3));
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !wb_valid, "R10 reset state",
            {busy, done, mem_req, wb_valid}, 4'b0000);
        rst_n = 1'b1;

        do_op("R3 load 8->16 zext post", 0, 0, 1, 0, 0, 1, 32'h10, 32'h0, '0, 0);
        do_op("R4 load 8->16 sext post", 0, 0, 1, 1, 0, 1, 32'h10, 32'h0, '0, 0);
        do_op("R4 load 8->32 sext", 0, 0, 2, 1, 0, 1, 32'h21, 32'h0, '0, 0);
        do_op("R3 load 8->32 zext", 0, 0, 2, 0, 0, 0, 32'h21, 32'h0, '0, 0);
        do_op("R4 load 16->32 sext", 0, 1, 2, 1, 0, 1, 32'h40, 32'h0, '0, 0);
        do_op("R3 load 16->32 zext", 0, 1, 2, 0, 0, 1, 32'h40, 32'h0, '0, 0);
        do_op("R5 load 32->32", 0, 2, 2, 1, 0, 1, 32'h60, 32'h0, '0, 0);
        do_op("R5 load 8->8", 0, 0, 0, 1, 0, 1, 32'h83, 32'h0, '0, 0);
        do_op("R7 load pre-inc negative", 0, 0, 1, 1, 1, 1, 32'h90, 32'hFFFF_FFF8, '0, 0);
        do_op("R8 load with mid-op and done pokes", 0, 1, 2, 1, 0, 1, 32'h50, 32'h0, '0, 1);
        do_op("R6 store 16->8", 1, 0, 1, 0, 0, 1, 32'hA0, 32'h0,
              128'hF1E2_D3C4_B5A6_9788_7766_5544_3322_1100, 0);
        do_op("R6 store 32->8", 1, 0, 2, 0, 1, 1, 32'hB0, 32'h4,
              128'h8899_AABB_CCDD_EEFF_0123_4567_89AB_CDEF, 0);
        do_op("R6 store 32->16", 1, 1, 2, 0, 0, 1, 32'hC0, 32'h0,
              128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100, 0);
        do_op("R5 store 32->32", 1, 2, 2, 0, 0, 0, 32'hD8, 32'h0,
              128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0, 1);
        do_op("R3 reload stored narrow bytes", 0, 0, 1, 0, 0, 1, 32'hA0, 32'h0, '0, 0);
        do_op("R9 load 16->8 illegal", 0, 1, 0, 0, 0, 1, 32'h10, 32'h0, '0, 0);
        do_op("R9 store reserved code", 1, 3, 2, 0, 0, 1, 32'h10, 32'h0, '1, 0);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R10 all completions seen", 128'(sb.size()), 128'(0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule